// File: doc/BRIEF.md
# Speculative Memory Dependence Table

This block watches memory accesses made by four threads that run one loop's iterations at once on four cores. The cores commit in a fixed rotating order. It records, for each word of a cache line, which cores have loaded it and which have stored to it while they were speculative. When a speculative load arrives, the block names the core whose private cache must supply the word, or sends the load to L2. When a store arrives, it works out which later threads read the word too early and must be squashed. It also works out which earlier threads must mark their copy of the word for flushing, and which later threads must drop their copy.

Each request carries the issuing core, a word address and an order mask. The order mask is a thermometer code: it has one more ones than the requester's distance from the non-speculative thread. The table is set-associative and indexed by line address. A speculative request that needs a new entry in a full set waits until a way becomes free. A way becomes free when a core's bits are cleared, which happens on commit or squash.

The controller has three states. SDT_IDLE accepts a request. SDT_LOOKUP searches the set and either completes or moves to SDT_WAIT_FREE. SDT_WAIT_FREE re-checks the set every cycle and completes once a way is free. The transitions are:
- accept: SDT_IDLE to SDT_LOOKUP.
- done: SDT_LOOKUP or SDT_WAIT_FREE to SDT_IDLE.
- block: SDT_LOOKUP to SDT_WAIT_FREE.
- hold: SDT_WAIT_FREE to itself.

Top module: `spec_dep_table`

## Requirements
- R1: After reset `req_ready` is 1, `stall` is 0 and `rsp_valid` is 0. The table is empty, so no later store finds a squash target left over from before reset.
- R2: A request is taken in the cycle where `req_valid` and `req_ready` are both 1. If it does not stall, `rsp_valid` pulses for one cycle exactly two rising edges later. `req_ready` stays 0 until then.
- R3: A speculative load that misses the table allocates an entry, records its own Load bit and answers `rsp_from_l2`=1.
- R4: The order mask has rank+1 low ones: 0001 is the non-speculative thread and 1111 is the third successor. The predecessor at distance k is core (core-k) mod 4. On a speculative load, the nearest core at distances 0 to rank whose Store bit is set for that word is reported on `rsp_fwd_core`, with `rsp_fwd_valid`=1.
- R5: A load finds no Store bit in its window when the only Store bits belong to its successors, or when no core has one. It then answers `rsp_from_l2`=1 and `rsp_fwd_valid`=0. A non-speculative load always answers from L2.
- R6: A request from the non-speculative thread never sets bits, never allocates and never stalls, even when its set is full.
- R7: On a store, the successors are core (core+k) mod 4 for k=1 to 3-rank. They are scanned nearest first. The first successor with its Load bit set is squashed, along with every later successor. A successor with only its Store bit set ends the scan with no squash. `rsp_squash` has one bit per core id.
- R8: After a store, `rsp_flush` has a bit for every predecessor whose Load or Store bit is set for that word.
- R9: After a store, `rsp_inval` covers successors nearest first, up to but not including the first one whose Store bit is set. On a miss it covers all successors.
- R10: A speculative request that misses while every way of its set is in use holds `stall`=1 and `req_ready`=0. When a way frees, it completes with a response the next edge.
- R11: `clr_valid` clears every Load and Store bit of `clr_core` across the table. An entry left with no bits becomes free. A clear in the same cycle as a lookup takes effect before that lookup.
- R12: Bits are kept per word. An access to one word of a line neither squashes nor forwards on account of another word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller is idle and takes a request |
| req_is_store | input | 1 | 1 for store, 0 for load |
| req_core | input | CID_W | Issuing core |
| req_addr | input | ADDR_W | Word address: word, then set, then tag |
| req_order_mask | input | NCORE | Thermometer order mask of the requester |
| clr_valid | input | 1 | Clear one core's bits this cycle |
| clr_core | input | CID_W | Core whose bits are cleared |
| stall | output | 1 | Request waits for a free way |
| rsp_valid | output | 1 | Response pulse |
| rsp_fwd_valid | output | 1 | Load is supplied by another core's cache |
| rsp_fwd_core | output | CID_W | Supplying core; its safe-write mark must clear |
| rsp_from_l2 | output | 1 | Load goes to L2 |
| rsp_squash | output | NCORE | Cores to squash and restart |
| rsp_flush | output | NCORE | Predecessors that must flag the word for flushing |
| rsp_inval | output | NCORE | Successors that must invalidate the word |

## Verification
The bench sweeps every mix of Load and Store bits over the four ranks of one word. It probes with each rank as loader and as storer, and rotates the non-speculative core so that the modular core numbering wraps. A scan that ignored an intervening Store bit would squash threads on a false output dependence. A scan that ran in the wrong direction would name the farthest producer instead of the nearest one.

Directed cases cover the following:
- Filling a set and then checking that a non-speculative store still passes through without stalling.
- Freeing a way by a clear in the very cycle of a stalled lookup. Applying the clear after the lookup would lose the new Load bit or keep stalling.
- Accesses to two words of one line, to show that a line-wide check would squash threads that never touched the word.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    typedef enum logic [1:0] {
        SDT_IDLE      = 2'd0,
        SDT_LOOKUP    = 2'd1,
        SDT_WAIT_FREE = 2'd2
    } sdt_state_e;

    // number of ones minus one: distance from the non-speculative thread
    function automatic int unsigned mask_rank(input logic [7:0] m);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) n++;
        end
        return (n == 0) ? 0 : n - 1;
    endfunction

endpackage

// File: rtl/sdt_way_pick.sv
module sdt_way_pick #(
    parameter int NWAYS = 8,
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic [NWAYS-1:0] live,
    input  logic [NWAYS-1:0] match,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic             free_any,
    output logic [WAY_W-1:0] free_way
);

    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        free_any = 1'b0;
        free_way = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (match[w] && !hit) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!live[w] && !free_any) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/sdt_dep_scan.sv
module sdt_dep_scan #(
    parameter int NCORE = 4,
    localparam int CID_W = $clog2(NCORE)
) (
    input  logic [NCORE-1:0] ld_bits,
    input  logic [NCORE-1:0] st_bits,
    input  logic [CID_W-1:0] core,
    input  logic [CID_W-1:0] rank,
    output logic             fwd_hit,
    output logic [CID_W-1:0] fwd_core,
    output logic [NCORE-1:0] squash,
    output logic [NCORE-1:0] flush,
    output logic [NCORE-1:0] inval
);

    logic             fwd_done;
    logic             viol_seen;
    logic             viol_stop;
    logic             inval_stop;
    logic [CID_W-1:0] pc;
    logic [CID_W-1:0] sc;

    // predecessor side: forwarding source and flush marks
    always_comb begin
        fwd_hit  = 1'b0;
        fwd_core = '0;
        fwd_done = 1'b0;
        flush    = '0;
        pc       = '0;
        for (int k = 0; k < NCORE; k++) begin
            if (k <= int'(rank)) begin
                pc = core - CID_W'(k);
                if (!fwd_done && st_bits[pc]) begin
                    fwd_hit  = 1'b1;
                    fwd_core = pc;
                    fwd_done = 1'b1;
                end
                if (k > 0) flush[pc] = ld_bits[pc] | st_bits[pc];
            end
        end
    end

    // successor side: violations and invalidations
    always_comb begin
        squash     = '0;
        inval      = '0;
        viol_seen  = 1'b0;
        viol_stop  = 1'b0;
        inval_stop = 1'b0;
        sc         = '0;
        for (int k = 1; k < NCORE; k++) begin
            if (k <= (NCORE - 1 - int'(rank))) begin
                sc = core + CID_W'(k);
                if (!inval_stop) begin
                    if (st_bits[sc]) inval_stop = 1'b1;
                    else             inval[sc]  = 1'b1;
                end
                if (viol_seen) begin
                    squash[sc] = 1'b1;
                end else if (!viol_stop) begin
                    if (ld_bits[sc]) begin
                        viol_seen  = 1'b1;
                        squash[sc] = 1'b1;
                    end else if (st_bits[sc]) begin
                        viol_stop = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spec_dep_table.sv
module spec_dep_table
    import sdt_pkg::*;
#(
    parameter int NCORE      = 4,
    parameter int NSETS      = 8,
    parameter int NWAYS      = 8,
    parameter int LINE_WORDS = 4,
    parameter int ADDR_W     = 32,
    localparam int CID_W = $clog2(NCORE),
    localparam int WB    = $clog2(LINE_WORDS),
    localparam int SB    = $clog2(NSETS),
    localparam int TAG_W = ADDR_W - WB - SB,
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_store,
    input  logic [CID_W-1:0]  req_core,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NCORE-1:0]  req_order_mask,
    input  logic              clr_valid,
    input  logic [CID_W-1:0]  clr_core,
    output logic              stall,
    output logic              rsp_valid,
    output logic              rsp_fwd_valid,
    output logic [CID_W-1:0]  rsp_fwd_core,
    output logic              rsp_from_l2,
    output logic [NCORE-1:0]  rsp_squash,
    output logic [NCORE-1:0]  rsp_flush,
    output logic [NCORE-1:0]  rsp_inval
);

    sdt_state_e state_q, state_d;

    logic              valid_q [NSETS][NWAYS];
    logic [TAG_W-1:0]  tag_q   [NSETS][NWAYS];
    logic [NCORE-1:0]  ld_q    [NSETS][NWAYS][LINE_WORDS];
    logic [NCORE-1:0]  st_q    [NSETS][NWAYS][LINE_WORDS];
    logic              keep_all[NSETS][NWAYS];

    logic              q_store;
    logic [CID_W-1:0]  q_core;
    logic [ADDR_W-1:0] q_addr;
    logic [CID_W-1:0]  q_rank;

    logic [SB-1:0]     q_set;
    logic [WB-1:0]     q_word;
    logic [TAG_W-1:0]  q_tag;
    logic [NCORE-1:0]  clr_vec;
    logic [NCORE-1:0]  own_vec;
    logic [NWAYS-1:0]  live;
    logic [NWAYS-1:0]  match;
    logic              hit, free_any;
    logic [WAY_W-1:0]  hit_way, free_way, tgt_way;
    logic [NCORE-1:0]  ld_w, st_w;
    logic              in_op, spec, block, do_write;

    logic              s_fwd_hit;
    logic [CID_W-1:0]  s_fwd_core;
    logic [NCORE-1:0]  s_squash, s_flush, s_inval;

    assign q_word = q_addr[WB-1:0];
    assign q_set  = q_addr[WB +: SB];
    assign q_tag  = q_addr[ADDR_W-1 : WB+SB];

    always_comb begin
        clr_vec = '0;
        if (clr_valid) clr_vec[clr_core] = 1'b1;
        own_vec = '0;
        own_vec[q_core] = 1'b1;
    end

    // an entry survives a clear if any bit outside the cleared core remains
    always_comb begin
        for (int s = 0; s < NSETS; s++) begin
            for (int w = 0; w < NWAYS; w++) begin
                keep_all[s][w] = 1'b0;
                for (int d = 0; d < LINE_WORDS; d++) begin
                    keep_all[s][w] = keep_all[s][w] |
                        (|((ld_q[s][w][d] | st_q[s][w][d]) & ~clr_vec));
                end
            end
        end
    end

    always_comb begin
        for (int w = 0; w < NWAYS; w++) begin
            live[w]  = valid_q[q_set][w] & keep_all[q_set][w];
            match[w] = live[w] && (tag_q[q_set][w] == q_tag);
        end
    end

    sdt_way_pick #(.NWAYS(NWAYS)) u_pick (
        .live     (live),
        .match    (match),
        .hit      (hit),
        .hit_way  (hit_way),
        .free_any (free_any),
        .free_way (free_way)
    );

    assign tgt_way = hit ? hit_way : free_way;
    assign ld_w    = hit ? (ld_q[q_set][hit_way][q_word] & ~clr_vec) : '0;
    assign st_w    = hit ? (st_q[q_set][hit_way][q_word] & ~clr_vec) : '0;

    sdt_dep_scan #(.NCORE(NCORE)) u_scan (
        .ld_bits  (ld_w),
        .st_bits  (st_w),
        .core     (q_core),
        .rank     (q_rank),
        .fwd_hit  (s_fwd_hit),
        .fwd_core (s_fwd_core),
        .squash   (s_squash),
        .flush    (s_flush),
        .inval    (s_inval)
    );

    assign in_op    = (state_q == SDT_LOOKUP) || (state_q == SDT_WAIT_FREE);
    assign spec     = (q_rank != '0);
    assign block    = in_op && spec && !hit && !free_any;
    assign do_write = in_op && spec && !block;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SDT_IDLE:      if (req_valid) state_d = SDT_LOOKUP;
            SDT_LOOKUP:    state_d = block ? SDT_WAIT_FREE : SDT_IDLE;
            SDT_WAIT_FREE: state_d = block ? SDT_WAIT_FREE : SDT_IDLE;
            default:       state_d = SDT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SDT_IDLE;
        else        state_q <= state_d;
    end

    // state-decoded outputs
    always_comb begin
        req_ready = 1'b0;
        stall     = 1'b0;
        unique case (state_q)
            SDT_IDLE:      req_ready = 1'b1;
            SDT_LOOKUP:    ;
            SDT_WAIT_FREE: stall = 1'b1;
            default:       ;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_store <= 1'b0;
            q_core  <= '0;
            q_addr  <= '0;
            q_rank  <= '0;
        end else if (state_q == SDT_IDLE && req_valid) begin
            q_store <= req_is_store;
            q_core  <= req_core;
            q_addr  <= req_addr;
            q_rank  <= CID_W'(mask_rank(8'(req_order_mask)));
        end
    end

    // table: clear first, then the lookup's own update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                for (int w = 0; w < NWAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    tag_q[s][w]   <= '0;
                    for (int d = 0; d < LINE_WORDS; d++) begin
                        ld_q[s][w][d] <= '0;
                        st_q[s][w][d] <= '0;
                    end
                end
            end
        end else begin
            for (int s = 0; s < NSETS; s++) begin
                for (int w = 0; w < NWAYS; w++) begin
                    valid_q[s][w] <= valid_q[s][w] & keep_all[s][w];
                    for (int d = 0; d < LINE_WORDS; d++) begin
                        ld_q[s][w][d] <= ld_q[s][w][d] & ~clr_vec;
                        st_q[s][w][d] <= st_q[s][w][d] & ~clr_vec;
                    end
                end
            end
            if (do_write) begin
                valid_q[q_set][tgt_way] <= 1'b1;
                tag_q[q_set][tgt_way]   <= q_tag;
                if (!hit) begin
                    for (int d = 0; d < LINE_WORDS; d++) begin
                        ld_q[q_set][tgt_way][d] <= '0;
                        st_q[q_set][tgt_way][d] <= '0;
                    end
                end
                if (q_store) st_q[q_set][tgt_way][q_word] <= st_w | own_vec;
                else         ld_q[q_set][tgt_way][q_word] <= ld_w | own_vec;
            end
        end
    end

    // response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_fwd_valid <= 1'b0;
            rsp_fwd_core  <= '0;
            rsp_from_l2   <= 1'b0;
            rsp_squash    <= '0;
            rsp_flush     <= '0;
            rsp_inval     <= '0;
        end else begin
            rsp_valid     <= in_op && !block;
            rsp_fwd_valid <= 1'b0;
            rsp_fwd_core  <= '0;
            rsp_from_l2   <= 1'b0;
            rsp_squash    <= '0;
            rsp_flush     <= '0;
            rsp_inval     <= '0;
            if (in_op && !block) begin
                if (q_store) begin
                    rsp_squash <= s_squash;
                    rsp_flush  <= s_flush;
                    rsp_inval  <= s_inval;
                end else begin
                    rsp_fwd_valid <= spec && s_fwd_hit;
                    rsp_fwd_core  <= (spec && s_fwd_hit) ? s_fwd_core : '0;
                    rsp_from_l2   <= !(spec && s_fwd_hit);
                end
            end
        end
    end

endmodule

// File: rtl/sdt_checker.sv
module sdt_checker #(
    parameter int NCORE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             stall,
    input logic             rsp_valid,
    input logic             rsp_fwd_valid,
    input logic             rsp_from_l2,
    input logic [NCORE-1:0] rsp_squash,
    input logic [NCORE-1:0] rsp_flush
);

    assert_accept_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 (rsp_valid || stall));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_one_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0({rsp_fwd_valid, rsp_from_l2}));

    assert_sides_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_flush & rsp_squash) == '0));

    assert_wait_ends_in_reply_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> rsp_valid);

    assert_no_reply_while_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !rsp_valid);

endmodule

bind spec_dep_table sdt_checker #(.NCORE(NCORE)) u_sdt_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .stall         (stall),
    .rsp_valid     (rsp_valid),
    .rsp_fwd_valid (rsp_fwd_valid),
    .rsp_from_l2   (rsp_from_l2),
    .rsp_squash    (rsp_squash),
    .rsp_flush     (rsp_flush)
);

// File: tb/tb_spec_dep_table.sv
module tb_spec_dep_table;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_is_store = 1'b0;
    logic [1:0]  req_core = '0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_order_mask = 4'b0001;
    logic        clr_valid = 1'b0;
    logic [1:0]  clr_core = '0;
    logic        stall;
    logic        rsp_valid;
    logic        rsp_fwd_valid;
    logic [1:0]  rsp_fwd_core;
    logic        rsp_from_l2;
    logic [3:0]  rsp_squash, rsp_flush, rsp_inval;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // captured response
    bit       c_fwd, c_l2;
    int       c_fcore;
    bit [3:0] c_sq, c_fl, c_iv;

    spec_dep_table dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_is_store(req_is_store), .req_core(req_core),
        .req_addr(req_addr), .req_order_mask(req_order_mask),
        .clr_valid(clr_valid), .clr_core(clr_core),
        .stall(stall), .rsp_valid(rsp_valid),
        .rsp_fwd_valid(rsp_fwd_valid), .rsp_fwd_core(rsp_fwd_core),
        .rsp_from_l2(rsp_from_l2), .rsp_squash(rsp_squash),
        .rsp_flush(rsp_flush), .rsp_inval(rsp_inval)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            finish_run();
        end
    end

    function automatic logic [31:0] line_addr(input int tag, input int set, input int word);
        return 32'((tag << 5) | (set << 2) | word);
    endfunction

    task automatic do_op(input bit st, input int core, input int rank,
                         input logic [31:0] addr, output int lat);
        @(negedge clk);
        req_valid      = 1'b1;
        req_is_store   = st;
        req_core       = 2'(core);
        req_order_mask = 4'((1 << (rank + 1)) - 1);
        req_addr       = addr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        c_fwd   = rsp_fwd_valid;
        c_fcore = int'(rsp_fwd_core);
        c_l2    = rsp_from_l2;
        c_sq    = rsp_squash;
        c_fl    = rsp_flush;
        c_iv    = rsp_inval;
    endtask

    task automatic clear_all();
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            clr_valid = 1'b1;
            clr_core  = 2'(c);
        end
        @(negedge clk);
        clr_valid = 1'b0;
    endtask

    initial begin
        int lat;
        bit [3:0] mL, mS;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(stall == 1'b0, "R1", "stall", stall, 0);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        do_op(1'b1, 0, 0, line_addr(5, 1, 0), lat);
        check(c_sq == 4'b0000, "R1", "squash on empty table", c_sq, 0);

        // R3 + R2: speculative load miss goes to L2, two-edge latency
        do_op(1'b0, 1, 1, line_addr(6, 2, 3), lat);
        check(lat == 2, "R2", "latency", lat, 2);
        check(c_l2 == 1'b1 && c_fwd == 1'b0, "R3", "load miss from_l2", c_l2, 1);
        do_op(1'b1, 0, 0, line_addr(6, 2, 3), lat);
        check(c_sq == 4'b1110, "R3", "recorded load bit squashes", c_sq, 14);
        clear_all();

        // R12: word isolation
        do_op(1'b0, 2, 2, line_addr(9, 4, 1), lat);
        do_op(1'b1, 0, 0, line_addr(9, 4, 2), lat);
        check(c_sq == 4'b0000, "R12", "other word squash", c_sq, 0);
        do_op(1'b1, 0, 0, line_addr(9, 4, 1), lat);
        check(c_sq == 4'b1100, "R12", "same word squash", c_sq, 12);
        clear_all();

        // sweep: every L/S mix over ranks, every probe rank, both ops
        for (int scn = 0; scn < 2048; scn++) begin
            int p, probe, pr, op, base, pcore;
            int e_fcore;
            bit e_fwd, e_l2, stop, viol, istop;
            bit [3:0] e_sq, e_fl, e_iv;
            logic [31:0] a;
            p     = scn % 256;
            probe = scn / 256;
            pr    = probe % 4;
            op    = probe / 4;
            base  = (p + probe) % 4;
            a     = 32'((scn << 2) | 1);
            mL = '0;
            mS = '0;
            for (int j = 0; j < 4; j++) begin
                int c;
                c = (base + j) % 4;
                if (((p >> (2*j)) & 1) != 0) begin
                    do_op(1'b0, c, j, a, lat);
                    if (j > 0) mL[c] = 1'b1;
                end
                if (((p >> (2*j+1)) & 1) != 0) begin
                    do_op(1'b1, c, j, a, lat);
                    if (j > 0) mS[c] = 1'b1;
                end
            end
            pcore = (base + pr) % 4;
            // expected, from the requirement text
            e_fwd = 0; e_fcore = 0; e_l2 = 0; e_sq = '0; e_fl = '0; e_iv = '0;
            if (op == 0) begin
                stop = 0;
                if (pr > 0) begin
                    for (int k = 0; k <= pr; k++) begin
                        int c;
                        c = (pcore - k + 4) % 4;
                        if (!stop && mS[c]) begin
                            e_fwd = 1; e_fcore = c; stop = 1;
                        end
                    end
                end
                e_l2 = !e_fwd;
            end else begin
                for (int k = 1; k <= pr; k++) begin
                    int c;
                    c = (pcore - k + 4) % 4;
                    e_fl[c] = mL[c] | mS[c];
                end
                stop = 0; viol = 0; istop = 0;
                for (int k = 1; k <= 3 - pr; k++) begin
                    int c;
                    c = (pcore + k) % 4;
                    if (!istop) begin
                        if (mS[c]) istop = 1;
                        else e_iv[c] = 1;
                    end
                    if (viol) e_sq[c] = 1;
                    else if (!stop) begin
                        if (mL[c]) begin viol = 1; e_sq[c] = 1; end
                        else if (mS[c]) stop = 1;
                    end
                end
            end
            do_op(op[0], pcore, pr, a, lat);
            if (op == 0) begin
                check(c_fwd == e_fwd && (!e_fwd || c_fcore == e_fcore), "R4",
                      "forward source", c_fwd ? c_fcore : -1, e_fwd ? e_fcore : -1);
                check(c_l2 == e_l2, "R5", "from_l2", c_l2, e_l2);
            end else begin
                check(c_sq == e_sq, "R7", "squash", c_sq, e_sq);
                check(c_fl == e_fl, "R8", "flush", c_fl, e_fl);
                check(c_iv == e_iv, "R9", "inval", c_iv, e_iv);
            end
            clear_all();
        end

        // fill set 3 with core 1 (rank 1) entries
        for (int t = 0; t < 8; t++) do_op(1'b0, 1, 1, line_addr(t, 3, 0), lat);

        // R6: non-speculative store into the full set passes through
        do_op(1'b1, 0, 0, line_addr(20, 3, 0), lat);
        check(lat == 2, "R6", "no stall latency", lat, 2);
        check(c_sq == 4'b0000 && c_iv == 4'b1110, "R6", "store miss inval",
              c_iv, 14);

        // R10: speculative miss in full set stalls
        @(negedge clk);
        req_valid = 1'b1; req_is_store = 1'b0; req_core = 2'd1;
        req_order_mask = 4'b0011; req_addr = line_addr(8, 3, 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(stall == 1'b1, "R10", "stall high", stall, 1);
        check(req_ready == 1'b0, "R10", "ready low", req_ready, 0);
        check(rsp_valid == 1'b0, "R10", "no reply", rsp_valid, 0);
        clr_valid = 1'b1; clr_core = 2'd1;
        @(negedge clk);
        clr_valid = 1'b0;
        check(rsp_valid == 1'b1 && rsp_from_l2 == 1'b1, "R10", "reply after free",
              rsp_valid, 1);
        check(stall == 1'b0, "R11", "clear frees way same cycle", stall, 0);

        // R11: new load bit kept, old bits gone
        do_op(1'b1, 0, 0, line_addr(8, 3, 0), lat);
        check(c_sq == 4'b1110, "R11", "bit recorded after clear", c_sq, 14);
        do_op(1'b1, 0, 0, line_addr(0, 3, 0), lat);
        check(c_sq == 4'b0000, "R11", "cleared bits gone", c_sq, 0);

        done = 1;
        finish_run();
    end

endmodule